// File: doc/BRIEF.md
# Buffer Load Splitter with Descriptor Bounds Check

This block serves buffer loads issued by a shader core. Each load comes with a buffer descriptor (a base byte address and a buffer length in bytes), a byte offset into the buffer and an access width of one, two or four 32-bit words. The block turns the load into one or more read requests on a simple valid/ready memory channel. It collects the returned words into a result of up to four lanes and hands that result back on a valid/ready response channel.

Bounds are checked word by word against the descriptor length. Words past the end of the buffer read as zero and are never requested from memory. A wide access goes out as a single request only when it is fully in range and its start is allowed for that width. Either the start is a multiple of the access size, or a configuration input permits wide reads from any word boundary. Otherwise the load is broken into single-word reads. An offset that is not a multiple of four, or an illegal width code, gives an error response with zero data and no memory traffic. Only one load is in flight at a time. The reset input is expected to be asserted asynchronously and released in step with the clock.

Top module: `bufld_splitter`

## Requirements
- R1: While reset is asserted, ld_ready is 1 and rsp_valid and mem_req_valid are both 0.
- R2: If ld_offset[1:0] is not 0, or ld_width is 3, the response carries rsp_err=1 and all-zero data, and no memory request is issued.
- R3: ld_width is coded 0 = one word (4 bytes), 1 = two words (8 bytes) and 2 = four words (16 bytes). An in-range one-word load issues exactly one request with mem_req_len=0 at address ld_base+ld_offset.
- R4: A fully in-range two-word or four-word load whose offset is a multiple of its byte size issues one request at ld_base+ld_offset. The mem_req_len of that request equals the width code.
- R5: When cfg_free_align=0, a fully in-range wide load whose offset is not a multiple of its byte size issues one single-word request (mem_req_len=0) per word. The requests go in ascending address order, and each address is ld_base+ld_offset+4k.
- R6: When cfg_free_align=1, a fully in-range wide load at any word-aligned offset issues one request whose mem_req_len equals the width code.
- R7: Word k of a load is in range only if ld_offset+4k+4 <= ld_size. This sum is computed without overflow. A partially in-range load issues single-word requests for the in-range words only, in ascending order, and returns zero in the other lanes.
- R8: A load with no in-range word returns all-zero data with rsp_err=0 and issues no memory request.
- R9: Word k of the load is returned in rsp_data[32k+31:32k]. Lanes past the requested width are zero. Word j of a memory response sits in mem_rsp_data[32j+31:32j].
- R10: ld_ready is 0 from the cycle after a load is accepted until the cycle after its response is accepted. At most one memory request is outstanding, and a request is held stable until mem_req_ready.
- R11: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_data and rsp_err stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_free_align | input | 1 | 1 allows wide reads from any word boundary |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load request accepted when high with ld_valid |
| ld_base | input | AW | Descriptor base byte address |
| ld_size | input | AW | Descriptor length in bytes |
| ld_offset | input | AW | Byte offset into the buffer |
| ld_width | input | 2 | Access width code (0: 4 B, 1: 8 B, 2: 16 B, 3: illegal) |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result accepted when high with rsp_valid |
| rsp_data | output | 128 | Assembled result, word k in lane k |
| rsp_err | output | 1 | Misaligned offset or illegal width |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | AW | Byte address of the first word read |
| mem_req_len | output | 2 | Words to read, same code as ld_width |
| mem_rsp_valid | input | 1 | Memory read data valid (one cycle) |
| mem_rsp_data | input | 128 | Memory read data, word j in lane j |

## Verification
Naturally aligned wide loads, loads that are only word-aligned, and the same loads with cfg_free_align set are run against each other. This separates the single-request path from the word-split path. Loads that straddle or pass the end of the buffer, including an offset near the top of the address range, show whether bounds are taken per word and whether the overflow of offset+4k is handled. Misaligned offsets and the illegal width code show that errors take priority over bounds and never reach memory. A long run of mixed loads under random back-pressure on both handshakes checks request order, lane placement and response hold.

// File: rtl/bufld_pkg.sv
package bufld_pkg;
  localparam int WORD_W    = 32;
  localparam int MAX_WORDS = 4;
  localparam int LIDX_W    = $clog2(MAX_WORDS);
  localparam int DATA_W    = WORD_W * MAX_WORDS;

  typedef enum logic [1:0] {
    WID_1W  = 2'd0,
    WID_2W  = 2'd1,
    WID_4W  = 2'd2,
    WID_BAD = 2'd3
  } ld_width_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/bufld_bounds.sv
module bufld_bounds
  import bufld_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]        base,
  input  logic [AW-1:0]        size,
  input  logic [AW-1:0]        offset,
  input  ld_width_e            width,
  input  logic                 free_align,
  output logic                 err,
  output logic [MAX_WORDS-1:0] in_mask,
  output logic                 use_wide,
  output logic [AW-1:0]        start_addr
);
  logic [MAX_WORDS-1:0] want_mask;
  logic                 nat_aligned;

  always_comb begin
    unique case (width)
      WID_1W:  want_mask = 4'b0001;
      WID_2W:  want_mask = 4'b0011;
      WID_4W:  want_mask = 4'b1111;
      default: want_mask = 4'b0000;
    endcase
  end

  always_comb begin
    unique case (width)
      WID_2W:  nat_aligned = (offset[2] == 1'b0);
      WID_4W:  nat_aligned = (offset[3:2] == 2'b00);
      default: nat_aligned = 1'b1;
    endcase
  end

  // one end-of-word comparator per lane, one bit wider than the address
  for (genvar k = 0; k < MAX_WORDS; k++) begin : g_lane
    logic [AW:0] end_byte;
    assign end_byte   = {1'b0, offset} + (AW+1)'(4 * (k + 1));
    assign in_mask[k] = want_mask[k] && (end_byte <= {1'b0, size});
  end

  assign err        = (offset[1:0] != 2'b00) || (width == WID_BAD);
  assign use_wide   = (in_mask == want_mask) && (nat_aligned || free_align);
  assign start_addr = base + offset;
endmodule

// File: rtl/bufld_sequencer.sv
module bufld_sequencer
  import bufld_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_valid,
  input  logic                 plan_err,
  input  logic [MAX_WORDS-1:0] plan_mask,
  input  logic                 plan_wide,
  input  logic [AW-1:0]        plan_addr,
  input  ld_width_e            plan_width,
  input  logic                 mem_req_ready,
  input  logic                 mem_rsp_valid,
  input  logic                 rsp_ready,
  output logic                 ld_ready,
  output logic                 mem_req_valid,
  output logic [AW-1:0]        mem_req_addr,
  output ld_width_e            mem_req_len,
  output logic                 rsp_valid,
  output logic                 load_en,
  output logic                 cap_en,
  output logic                 wide_q,
  output logic [MAX_WORDS-1:0] wr_mask
);
  seq_state_e           state_q, state_n;
  logic [MAX_WORDS-1:0] pend_q, pend_n;
  logic                 wide_n;
  ld_width_e            len_q, len_n;
  logic [AW-1:0]        addr_q, addr_n;
  logic [MAX_WORDS-1:0] sel;
  logic [LIDX_W-1:0]    idx;

  // lowest pending lane goes first: ascending addresses
  always_comb begin
    sel = '0;
    idx = '0;
    for (int k = MAX_WORDS - 1; k >= 0; k--) begin
      if (pend_q[k]) begin
        sel    = '0;
        sel[k] = 1'b1;
        idx    = LIDX_W'(k);
      end
    end
  end

  always_comb begin
    state_n = state_q;
    pend_n  = pend_q;
    wide_n  = wide_q;
    len_n   = len_q;
    addr_n  = addr_q;
    load_en = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ld_valid) begin
          load_en = 1'b1;
          addr_n  = plan_addr;
          wide_n  = plan_wide;
          len_n   = plan_width;
          pend_n  = plan_err ? '0 : plan_mask;
          state_n = (plan_err || plan_mask == '0) ? ST_RESP : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (mem_req_ready) state_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          cap_en  = 1'b1;
          pend_n  = wide_q ? '0 : (pend_q & ~sel);
          state_n = (pend_n == '0) ? ST_RESP : ST_ISSUE;
        end
      end
      ST_RESP: begin
        if (rsp_ready) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      wide_q  <= 1'b0;
      len_q   <= WID_1W;
      addr_q  <= '0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      if (load_en) begin
        wide_q <= wide_n;
        len_q  <= len_n;
        addr_q <= addr_n;
      end
    end
  end

  assign ld_ready      = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign mem_req_addr  = addr_q + AW'({idx, 2'b00});
  assign mem_req_len   = wide_q ? len_q : WID_1W;
  assign wr_mask       = wide_q ? pend_q : sel;
endmodule

// File: rtl/bufld_gather.sv
module bufld_gather
  import bufld_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic                 err_in,
  input  logic                 cap_en,
  input  logic                 wide,
  input  logic [MAX_WORDS-1:0] wr_mask,
  input  logic [DATA_W-1:0]    mem_data,
  output logic [DATA_W-1:0]    data_q,
  output logic                 err_q
);
  logic [DATA_W-1:0] data_n;
  logic              err_n;

  always_comb begin
    data_n = data_q;
    err_n  = err_q;
    if (load_en) begin
      data_n = '0;
      err_n  = err_in;
    end else if (cap_en) begin
      for (int k = 0; k < MAX_WORDS; k++) begin
        if (wr_mask[k]) begin
          data_n[k*WORD_W +: WORD_W] = wide ? mem_data[k*WORD_W +: WORD_W]
                                            : mem_data[0 +: WORD_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (load_en || cap_en) begin
      data_q <= data_n;
      err_q  <= err_n;
    end
  end
endmodule

// File: rtl/bufld_splitter.sv
module bufld_splitter
  import bufld_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_free_align,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [AW-1:0]     ld_base,
  input  logic [AW-1:0]     ld_size,
  input  logic [AW-1:0]     ld_offset,
  input  logic [1:0]        ld_width,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  output logic [1:0]        mem_req_len,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  logic                 plan_err, plan_wide;
  logic [MAX_WORDS-1:0] plan_mask, wr_mask;
  logic [AW-1:0]        plan_addr;
  logic                 load_en, cap_en, wide_q;
  ld_width_e            req_len;

  bufld_bounds #(.AW(AW)) u_bounds (
    .base       (ld_base),
    .size       (ld_size),
    .offset     (ld_offset),
    .width      (ld_width_e'(ld_width)),
    .free_align (cfg_free_align),
    .err        (plan_err),
    .in_mask    (plan_mask),
    .use_wide   (plan_wide),
    .start_addr (plan_addr)
  );

  bufld_sequencer #(.AW(AW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_valid      (ld_valid),
    .plan_err      (plan_err),
    .plan_mask     (plan_mask),
    .plan_wide     (plan_wide),
    .plan_addr     (plan_addr),
    .plan_width    (ld_width_e'(ld_width)),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_ready     (rsp_ready),
    .ld_ready      (ld_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_req_len   (req_len),
    .rsp_valid     (rsp_valid),
    .load_en       (load_en),
    .cap_en        (cap_en),
    .wide_q        (wide_q),
    .wr_mask       (wr_mask)
  );

  bufld_gather u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .err_in   (plan_err),
    .cap_en   (cap_en),
    .wide     (wide_q),
    .wr_mask  (wr_mask),
    .mem_data (mem_rsp_data),
    .data_q   (rsp_data),
    .err_q    (rsp_err)
  );

  assign mem_req_len = req_len;
endmodule

// File: rtl/bufld_checker.sv
module bufld_checker
  import bufld_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_err,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [AW-1:0]     mem_req_addr,
  input logic [1:0]        mem_req_len
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (ld_ready && !rsp_valid && !mem_req_valid));

  a_r10_busy_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !ld_ready);

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len)));

  a_r10_no_req_during_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rsp_valid);

  a_r11_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  a_r2_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));

  a_r5_req_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_len != 2'd3));
endmodule

bind bufld_splitter bufld_checker #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ld_ready      (ld_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .rsp_err       (rsp_err),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_len   (mem_req_len)
);

// File: tb/tb_bufld_splitter.sv
`timescale 1ns/100ps
module tb_bufld_splitter;
  import bufld_pkg::*;
  localparam int AW  = 32;
  localparam int LAT = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_free_align;
  logic              ld_valid;
  logic              ld_ready;
  logic [AW-1:0]     ld_base, ld_size, ld_offset;
  logic [1:0]        ld_width;
  logic              rsp_valid, rsp_ready, rsp_err;
  logic [DATA_W-1:0] rsp_data;
  logic              mem_req_valid, mem_req_ready;
  logic [AW-1:0]     mem_req_addr;
  logic [1:0]        mem_req_len;
  logic              mem_rsp_valid;
  logic [DATA_W-1:0] mem_rsp_data;

  always #2.5 clk = ~clk;

  bufld_splitter #(.AW(AW)) dut (.*);

  typedef struct { logic [AW-1:0] addr; logic [1:0] len; string tag; } req_t;
  typedef struct { logic [DATA_W-1:0] data; logic err; string tag; } rsp_t;
  req_t exp_req[$];
  rsp_t exp_rsp[$];

  int n_cmp = 0;
  int n_bad = 0;
  bit busy = 0;
  bit done = 0;
  bit hold_prev = 0;
  logic [DATA_W-1:0] prev_data;
  logic              prev_err;

  function automatic logic [31:0] mw(logic [AW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  function automatic int words_of(logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 0;
  endfunction

  task automatic chk(string tag, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: expected memory requests and response per load
  function automatic void model(logic [AW-1:0] base, logic [AW-1:0] size,
                                logic [AW-1:0] off, logic [1:0] w, bit fr);
    int n; int cnt; bit all_in; bit alg; bit inr[4];
    logic [DATA_W-1:0] d; rsp_t r; req_t q;
    n = words_of(w);
    d = '0; cnt = 0; all_in = 1;
    if (w == 2'd3 || off[1:0] != 2'b00) begin
      r.data = '0; r.err = 1'b1; r.tag = "R2";
      exp_rsp.push_back(r);
      return;
    end
    for (int k = 0; k < 4; k++) begin
      longint unsigned e;
      e = {32'h0, off} + 64'(4 * (k + 1));
      inr[k] = (k < n) && (e <= {32'h0, size});
      if (inr[k]) begin
        cnt++;
        d[32*k +: 32] = mw(base + off + AW'(4 * k));
      end else if (k < n) all_in = 0;
    end
    alg = (n == 1) || (w == 2'd1 && off[2] == 1'b0) || (w == 2'd2 && off[3:2] == 2'b00);
    if (cnt == 0) begin
      r.tag = "R8";
    end else if (all_in && (alg || fr)) begin
      q.addr = base + off; q.len = w;
      q.tag  = (n == 1) ? "R3" : alg ? "R4" : "R6";
      exp_req.push_back(q);
      r.tag = "R9";
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (inr[k]) begin
          q.addr = base + off + AW'(4 * k); q.len = 2'd0;
          q.tag  = all_in ? "R5" : "R7";
          exp_req.push_back(q);
        end
      end
      r.tag = all_in ? "R9" : "R7";
    end
    r.data = d; r.err = 1'b0;
    exp_rsp.push_back(r);
  endfunction

  // per-clock comparison, sampled half a period away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk("R10", "ld_ready", {127'd0, ld_ready}, {127'd0, !busy});
      if (mem_req_valid && mem_req_ready) begin
        if (exp_req.size() == 0) chk("R8", "unexpected mem request", {94'd0, mem_req_addr, mem_req_len}, '0);
        else begin
          req_t q;
          q = exp_req.pop_front();
          chk(q.tag, "mem request addr/len", {94'd0, mem_req_addr, mem_req_len}, {94'd0, q.addr, q.len});
        end
      end
      if (hold_prev) begin
        chk("R11", "held response", {rsp_valid, rsp_err, rsp_data[125:0]}, {1'b1, prev_err, prev_data[125:0]});
      end
      hold_prev = rsp_valid && !rsp_ready;
      prev_data = rsp_data;
      prev_err  = rsp_err;
      if (rsp_valid && rsp_ready) begin
        busy = 0;
        if (exp_rsp.size() == 0) chk("R10", "unexpected response", rsp_data, '0);
        else begin
          rsp_t r;
          r = exp_rsp.pop_front();
          chk(r.tag, "response data", rsp_data, r.data);
          chk(r.tag, "response err", {127'd0, rsp_err}, {127'd0, r.err});
        end
      end
      if (ld_valid && ld_ready) busy = 1;
    end
  end

  // fixed-latency memory responder; unused lanes carry filler
  initial begin
    logic [AW-1:0] ra;
    logic [1:0]    rl;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && mem_req_valid && mem_req_ready) begin
        ra = mem_req_addr;
        rl = mem_req_len;
        repeat (LAT) @(posedge clk);
        #1;
        mem_rsp_valid = 1'b1;
        for (int j = 0; j < 4; j++)
          mem_rsp_data[32*j +: 32] = (j < words_of(rl)) ? mw(ra + AW'(4 * j)) : 32'hDEAD_BEEF;
        @(posedge clk);
        #1;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = {DATA_W{1'b1}};
      end
    end
  end

  // random back-pressure on both handshakes
  initial begin
    mem_req_ready = 1'b0;
    rsp_ready     = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      mem_req_ready = ($urandom % 4) != 0;
      rsp_ready     = ($urandom % 4) != 0;
    end
  end

  task automatic do_load(logic [AW-1:0] base, logic [AW-1:0] size,
                         logic [AW-1:0] off, logic [1:0] w, bit fr);
    model(base, size, off, w, fr);
    @(posedge clk);
    #1;
    ld_valid = 1'b1; ld_base = base; ld_size = size;
    ld_offset = off; ld_width = w; cfg_free_align = fr;
    do @(negedge clk); while (!ld_ready);
    @(posedge clk);
    #1;
    ld_valid = 1'b0;
    while (exp_rsp.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog expired actual=hung expected=idle");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; ld_valid = 1'b0; cfg_free_align = 1'b0;
    ld_base = '0; ld_size = '0; ld_offset = '0; ld_width = '0;
    repeat (3) begin
      @(negedge clk);
      chk("R1", "reset outputs", {125'd0, ld_ready, rsp_valid, mem_req_valid}, {125'd0, 3'b100});
    end
    @(posedge clk);
    #1 rst_n = 1'b1;

    do_load(32'h0000_1000, 32'd64, 32'd8,  2'd0, 0);  // R3 single word
    do_load(32'h0000_1000, 32'd64, 32'd8,  2'd1, 0);  // R4 8B natural
    do_load(32'h0000_1000, 32'd64, 32'd16, 2'd2, 0);  // R4 16B natural
    do_load(32'h0000_1000, 32'd64, 32'd4,  2'd1, 0);  // R5 split two
    do_load(32'h0000_1000, 32'd64, 32'd8,  2'd2, 0);  // R5 split four
    do_load(32'h0000_1000, 32'd64, 32'd4,  2'd2, 1);  // R6 free single
    do_load(32'h0000_1000, 32'd64, 32'd12, 2'd1, 1);  // R6 free single
    do_load(32'h0000_1000, 32'd64, 32'd6,  2'd1, 0);  // R2 misaligned
    do_load(32'h0000_1000, 32'd64, 32'd8,  2'd3, 0);  // R2 bad width
    do_load(32'h0000_1000, 32'd4,  32'd6,  2'd0, 0);  // R2 wins over bounds
    do_load(32'h0000_1000, 32'd40, 32'd32, 2'd2, 1);  // R7 partial
    do_load(32'h0000_1000, 32'd40, 32'd36, 2'd2, 0);  // R7 one word in
    do_load(32'h0000_1000, 32'd40, 32'd40, 2'd0, 0);  // R8 just past end
    do_load(32'h0000_1000, 32'd40, 32'd1000, 2'd2, 1); // R8 far out
    do_load(32'h0000_2000, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 2'd0, 0); // R7 overflow
    do_load(32'h0000_2000, 32'hFFFF_FFFF, 32'hFFFF_FFF8, 2'd2, 1); // R7 overflow wide
    do_load(32'hFFFF_FFF0, 32'd64, 32'd8, 2'd2, 1);   // R9 address wrap

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] b, s, o;
      b = {$urandom, 2'b00} & 32'hFFFF_FFFC;
      s = AW'(($urandom % 26) * 4);
      o = AW'(($urandom % 28) * 4) + ((($urandom % 8) == 0) ? AW'(2) : AW'(0));
      do_load(b, s, o, 2'($urandom % 4), 1'($urandom % 2));
    end

    repeat (10) @(negedge clk);
    chk("R10", "leftover expected items", {64'd0, 32'(exp_req.size()), 32'(exp_rsp.size())}, '0);
    finish_run();
  end
endmodule